// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is an on-chip synchronous memory of 36-bit words, built from four 9-bit byte lanes. It takes a fresh read or write command on every clock. The data phase of each command falls exactly two rising edges after the command is sampled, and this holds for reads and for writes alike. Because the two kinds of command line up, a write can follow a read, or a read can follow a write, with no idle cycle between them.

A command is loaded when the load/advance strobe is low and all three chip enables are true. Holding the strobe high instead continues the current four-beat burst. The burst wraps on the two low address bits, and a parameter picks linear or interleaved order. A low strobe with the chip deselected ends the burst and sends an empty slot down the pipe.

A clock-enable freezes the whole block. While it is high, the design behaves as if the edge never came. An asynchronous output-enable masks the read-data drive flag without touching the pipeline. Data-in and data-out are split buses, and `rdata_oe_o` marks the cycles in which `rdata_o` would drive the shared bus.

Top module: `zt_sram`

## Requirements
- R1: A command (address, and the read/write type with `rd_i`=1 meaning read) is captured only at an edge where `cke_n_i`=0, `adv_ld_n_i`=0, `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0. A low strobe with any chip enable false captures no command.
- R2: A read captured at edge k places the addressed word on `rdata_o` with `rdata_oe_o`=1 (when `oe_n_i`=0) from edge k+2 until edge k+3.
- R3: For a write captured at edge k, the data is taken from `wdata_i` at edge k+2. Reads and writes may alternate on consecutive edges, and a write never raises `rdata_oe_o`.
- R4: A write stores byte b (bits 9b+8..9b) only if `bw_n_i[b]` was 0 at the edge that issued that beat. Every other byte of the word keeps its old value.
- R5: `bw_n_i` has no effect on read beats. A read beat never changes the array.
- R6: With `adv_ld_n_i`=1 after a load, each edge issues the next burst beat of the same type. Address bits above bit 1 stay fixed. With the default linear order, the low two bits of beat n are (start+n) mod 4. Chip enables are ignored on advance edges.
- R7: With `adv_ld_n_i`=1 and no burst open (after reset, or after a deselect), no command is issued.
- R8: A deselect at edge k ends any burst, and `rdata_oe_o` is 0 from edge k+2 on, unless a later read command drives it.
- R9: At an edge with `cke_n_i`=1, no command is captured, nothing is written, and `rdata_o` and `rdata_oe_o` hold. The pipeline resumes at the next enabled edge as if no edge had happened.
- R10: `oe_n_i`=1 forces `rdata_oe_o` to 0 at once, without a clock edge, and leaves the pipeline untouched.
- R11: During reset, and until the first read reaches its data phase, `rdata_oe_o` is 0.
- R12: A read of an address written by the command just before it returns the new bytes merged with the old values of the unwritten bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address, sampled on load edges |
| adv_ld_n_i | input | 1 | Low: load a command; high: advance the burst |
| rd_i | input | 1 | 1 read, 0 write, sampled on load edges |
| cke_n_i | input | 1 | Active-low clock enable |
| cs1_n_i | input | 1 | Active-low chip enable |
| cs2_i | input | 1 | Active-high chip enable |
| cs3_n_i | input | 1 | Active-low chip enable |
| bw_n_i | input | NBYTES | Active-low byte write enables, bit b for byte b |
| wdata_i | input | NBYTES*BYTE_W | Write data, sampled two edges after its command |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| rdata_o | output | NBYTES*BYTE_W | Registered read data |
| rdata_oe_o | output | 1 | High when `rdata_o` should drive the bus |

## Verification
The bench targets these corner cases, and each one catches a specific kind of wrong design:
- Read directly after a write to the same address, with a partial byte mask. A design that reads the array one stage early, or merges bytes wrongly, returns stale or mixed words.
- A burst whose advance edges drop the chip enables, followed by strobe-high edges after a deselect. A design that checks the chip enables on advance edges cuts the burst short, and one that forgets to close the burst issues phantom beats.
- Clock-enable stalls placed inside read and write data phases. A design that lets any stage or the array move during a stall shifts data by a cycle or writes the wrong `wdata_i` word.
- Output-enable toggled between edges. A design that registers output-enable shows the mask one cycle late.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  localparam int BURST_BITS = 2;

  typedef enum logic {
    ORDER_INTERLEAVED = 1'b0,
    ORDER_LINEAR      = 1'b1
  } burst_order_e;

  // Low address bits of a burst beat, from the start offset and beat index.
  function automatic logic [BURST_BITS-1:0] burst_offset(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat,
    input burst_order_e          order
  );
    if (order == ORDER_LINEAR) return start + beat;
    return start ^ beat;
  endfunction

  function automatic logic chips_selected(input logic c1_n, input logic c2, input logic c3_n);
    return !c1_n && c2 && !c3_n;
  endfunction

endpackage

// File: rtl/zt_cmd_front.sv
module zt_cmd_front
  import zt_sram_pkg::*;
#(
  parameter int           AW    = 6,
  parameter int           NB    = 4,
  parameter burst_order_e ORDER = ORDER_LINEAR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv_ld_n,
  input  logic          rd,
  input  logic          sel,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] bw_n,
  output logic          nxt_valid,
  output logic          nxt_read,
  output logic [AW-1:0] nxt_addr,
  output logic [NB-1:0] nxt_bmask,
  output logic          ev_load,
  output logic          ev_desel,
  output logic          ev_adv
);

  logic                  burst_on;
  logic                  burst_rd;
  logic [AW-1:0]         base;
  logic [BURST_BITS-1:0] beat;
  logic [BURST_BITS-1:0] beat_nx;

  assign ev_load  = !adv_ld_n && sel;
  assign ev_desel = !adv_ld_n && !sel;
  assign ev_adv   = adv_ld_n && burst_on;
  assign beat_nx  = beat + 1'b1;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_read  = burst_rd;
    nxt_addr  = base;
    nxt_bmask = '0;
    if (ev_load) begin
      nxt_valid = 1'b1;
      nxt_read  = rd;
      nxt_addr  = addr;
      nxt_bmask = rd ? '0 : ~bw_n;
    end else if (ev_adv) begin
      nxt_valid = 1'b1;
      nxt_read  = burst_rd;
      nxt_addr  = {base[AW-1:BURST_BITS],
                   burst_offset(base[BURST_BITS-1:0], beat_nx, ORDER)};
      nxt_bmask = burst_rd ? '0 : ~bw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      burst_rd <= 1'b0;
      base     <= '0;
      beat     <= '0;
    end else if (en) begin
      if (ev_load) begin
        burst_on <= 1'b1;
        burst_rd <= rd;
        base     <= addr;
        beat     <= '0;
      end else if (ev_desel) begin
        burst_on <= 1'b0;
      end else if (ev_adv) begin
        beat     <= beat_nx;
      end
    end
  end

endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe #(
  parameter int AW  = 6,
  parameter int NB  = 4,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic          in_read,
  input  logic [AW-1:0] in_addr,
  input  logic [NB-1:0] in_bmask,
  output logic          head_valid,
  output logic          head_read,
  output logic [AW-1:0] head_addr,
  output logic [NB-1:0] head_bmask,
  output logic          tail_valid,
  output logic          tail_read,
  output logic [AW-1:0] tail_addr,
  output logic [NB-1:0] tail_bmask
);

  logic          v [LAT];
  logic          r [LAT];
  logic [AW-1:0] a [LAT];
  logic [NB-1:0] m [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        v[i] <= 1'b0;
        r[i] <= 1'b0;
        a[i] <= '0;
        m[i] <= '0;
      end
    end else if (en) begin
      v[0] <= in_valid;
      r[0] <= in_read;
      a[0] <= in_addr;
      m[0] <= in_bmask;
      for (int i = 1; i < LAT; i++) begin
        v[i] <= v[i-1];
        r[i] <= r[i-1];
        a[i] <= a[i-1];
        m[i] <= m[i-1];
      end
    end
  end

  assign head_valid = v[0];
  assign head_read  = r[0];
  assign head_addr  = a[0];
  assign head_bmask = m[0];
  assign tail_valid = v[LAT-1];
  assign tail_read  = r[LAT-1];
  assign tail_addr  = a[LAT-1];
  assign tail_bmask = m[LAT-1];

endmodule

// File: rtl/zt_word_array.sv
module zt_word_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             en,
  input  logic             wr,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wmask,
  input  logic [NB*BW-1:0] wdata,
  input  logic             rd,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] cells [DEPTH];
    logic [BW-1:0] q;

    always_ff @(posedge clk) begin
      if (en && wr && wmask[g]) cells[waddr] <= wdata[g*BW +: BW];
      if (en && rd)             q <= cells[raddr];
    end

    assign rdata[g*BW +: BW] = q;
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int           AW     = 6,
  parameter int           BYTE_W = 9,
  parameter int           NBYTES = 4,
  parameter burst_order_e ORDER  = ORDER_LINEAR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr_i,
  input  logic                     adv_ld_n_i,
  input  logic                     rd_i,
  input  logic                     cke_n_i,
  input  logic                     cs1_n_i,
  input  logic                     cs2_i,
  input  logic                     cs3_n_i,
  input  logic [NBYTES-1:0]        bw_n_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic                     oe_n_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o,
  output logic                     rdata_oe_o
);

  localparam int WORD_W = NBYTES * BYTE_W;
  localparam int LAT    = 2;

  logic              en;
  logic              sel;
  logic              nxt_valid, nxt_read;
  logic [AW-1:0]     nxt_addr;
  logic [NBYTES-1:0] nxt_bmask;
  logic              ev_load, ev_desel, ev_adv;
  logic              s1_valid, s1_read;
  logic [AW-1:0]     s1_addr;
  logic [NBYTES-1:0] s1_bmask;
  logic              s2_valid, s2_read;
  logic [AW-1:0]     s2_addr;
  logic [NBYTES-1:0] s2_bmask;
  logic              commit_wr, fetch_rd;
  logic              drv_q;
  logic [WORD_W-1:0] arr_rdata;

  assign en  = !cke_n_i;
  assign sel = chips_selected(cs1_n_i, cs2_i, cs3_n_i);

  zt_cmd_front #(.AW(AW), .NB(NBYTES), .ORDER(ORDER)) u_front (
    .clk(clk), .rst_n(rst_n), .en(en), .adv_ld_n(adv_ld_n_i), .rd(rd_i),
    .sel(sel), .addr(addr_i), .bw_n(bw_n_i),
    .nxt_valid(nxt_valid), .nxt_read(nxt_read), .nxt_addr(nxt_addr),
    .nxt_bmask(nxt_bmask), .ev_load(ev_load), .ev_desel(ev_desel), .ev_adv(ev_adv)
  );

  zt_cmd_pipe #(.AW(AW), .NB(NBYTES), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(nxt_valid), .in_read(nxt_read), .in_addr(nxt_addr), .in_bmask(nxt_bmask),
    .head_valid(s1_valid), .head_read(s1_read), .head_addr(s1_addr), .head_bmask(s1_bmask),
    .tail_valid(s2_valid), .tail_read(s2_read), .tail_addr(s2_addr), .tail_bmask(s2_bmask)
  );

  assign commit_wr = s2_valid && !s2_read;
  assign fetch_rd  = s2_valid && s2_read;

  zt_word_array #(.AW(AW), .NB(NBYTES), .BW(BYTE_W)) u_array (
    .clk(clk), .en(en), .wr(commit_wr), .waddr(s2_addr), .wmask(s2_bmask),
    .wdata(wdata_i), .rd(fetch_rd), .raddr(s2_addr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  drv_q <= 1'b0;
    else if (en) drv_q <= fetch_rd;
  end

  assign rdata_o    = arr_rdata;
  assign rdata_oe_o = drv_q && !oe_n_i;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int W  = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          oe_n_i,
  input logic          ev_load,
  input logic          ev_desel,
  input logic          ev_adv,
  input logic          s1_valid,
  input logic          s1_read,
  input logic [AW-1:0] s1_addr,
  input logic [NB-1:0] s1_bmask,
  input logic          s2_valid,
  input logic          s2_read,
  input logic          drv_q,
  input logic [W-1:0]  rdata_o,
  input logic          rdata_oe_o
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    en && ev_load |=> s1_valid && s1_addr == $past(addr_i) && s1_read == $past(rd_i)); // R1

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_load, ev_desel, ev_adv})); // R1

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    en && s2_valid && s2_read |=> drv_q); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    en && s2_valid && !s2_read |=> !rdata_oe_o); // R3

  AST_READ_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_read |-> s1_bmask == '0); // R5

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    en && ev_adv |=> s1_valid && s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])); // R6

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    en && !ev_load && !ev_adv |=> !s1_valid); // R7

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata_o) && $stable(drv_q) && $stable(s1_valid) && $stable(s2_valid) && $stable(s1_addr)); // R9

  AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !rdata_oe_o); // R10

endmodule

bind zt_sram zt_sram_chk #(.AW(AW), .NB(NBYTES), .W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .addr_i(addr_i), .rd_i(rd_i), .oe_n_i(oe_n_i),
  .ev_load(ev_load), .ev_desel(ev_desel), .ev_adv(ev_adv),
  .s1_valid(s1_valid), .s1_read(s1_read), .s1_addr(s1_addr), .s1_bmask(s1_bmask),
  .s2_valid(s2_valid), .s2_read(s2_read), .drv_q(drv_q),
  .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
);

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int W  = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adv_ld_n_i = 1'b0;
  logic          rd_i = 1'b1;
  logic          cke_n_i = 1'b0;
  logic          cs1_n_i = 1'b1;
  logic          cs2_i = 1'b1;
  logic          cs3_n_i = 1'b0;
  logic [NB-1:0] bw_n_i = '1;
  logic [W-1:0]  wdata_i = '0;
  logic          oe_n_i = 1'b0;
  logic [W-1:0]  rdata_o;
  logic          rdata_oe_o;

  always #2.5 clk = ~clk;

  zt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adv_ld_n_i(adv_ld_n_i), .rd_i(rd_i),
    .cke_n_i(cke_n_i), .cs1_n_i(cs1_n_i), .cs2_i(cs2_i), .cs3_n_i(cs3_n_i),
    .bw_n_i(bw_n_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string tag    = "R11";

  // Reference model state, built from the requirements.
  logic [W-1:0]  ref_mem [1 << AW];
  logic          m1v, m1rd, m2v, m2rd;
  logic [AW-1:0] m1a, m2a;
  logic [NB-1:0] m1m, m2m;
  logic          bon, brd;
  logic [AW-1:0] bbase;
  logic [1:0]    bcnt;
  logic          exp_drv = 1'b0;
  logic [W-1:0]  exp_dat = '0;

  task automatic chk(input logic ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m1v = 0; m1rd = 0; m1a = '0; m1m = '0;
    m2v = 0; m2rd = 0; m2a = '0; m2m = '0;
    bon = 0; brd = 0; bbase = '0; bcnt = '0;
    exp_drv = 0;
  endtask

  task automatic step(input logic adv_n, input logic rd, input logic [AW-1:0] a,
                      input logic cke_n, input logic c1n, input logic c2, input logic c3n,
                      input logic [NB-1:0] bwn, input logic oen);
    logic [63:0] rnd;
    logic        sel;
    @(negedge clk);
    rnd        = {$urandom(), $urandom()};
    adv_ld_n_i = adv_n; rd_i = rd; addr_i = a; cke_n_i = cke_n;
    cs1_n_i = c1n; cs2_i = c2; cs3_n_i = c3n; bw_n_i = bwn; oe_n_i = oen;
    wdata_i = rnd[W-1:0];
    #0.5;
    chk(rdata_oe_o === (exp_drv && !oen), "async drive (R10)", W'(rdata_oe_o), W'(exp_drv && !oen));
    @(posedge clk);
    #1;
    if (!cke_n) begin
      if (m2v && !m2rd)
        for (int b = 0; b < NB; b++)
          if (m2m[b]) ref_mem[m2a][b*BW +: BW] = wdata_i[b*BW +: BW];
      if (m2v && m2rd) exp_dat = ref_mem[m2a];
      exp_drv = m2v && m2rd;
      m2v = m1v; m2rd = m1rd; m2a = m1a; m2m = m1m;
      sel = !c1n && c2 && !c3n;
      if (!adv_n) begin
        if (sel) begin
          m1v = 1; m1rd = rd; m1a = a; m1m = rd ? '0 : ~bwn;
          bon = 1; brd = rd; bbase = a; bcnt = 0;
        end else begin
          m1v = 0; bon = 0;
        end
      end else if (bon) begin
        bcnt = bcnt + 2'd1;
        m1v  = 1; m1rd = brd;
        m1a  = {bbase[AW-1:2], 2'(bbase[1:0] + bcnt)};
        m1m  = brd ? '0 : ~bwn;
      end else begin
        m1v = 0;
      end
    end
    chk(rdata_oe_o === (exp_drv && !oen), "drive", W'(rdata_oe_o), W'(exp_drv && !oen));
    if (exp_drv && !oen) chk(rdata_o === exp_dat, "read data", rdata_o, exp_dat);
  endtask

  task automatic do_load(input logic rd, input logic [AW-1:0] a, input logic [NB-1:0] bwn);
    step(1'b0, rd, a, 1'b0, 1'b0, 1'b1, 1'b0, bwn, 1'b0);
  endtask

  task automatic do_adv(input logic [NB-1:0] bwn, input logic c1n);
    step(1'b1, 1'b0, '0, 1'b0, c1n, 1'b1, 1'b0, bwn, 1'b0);
  endtask

  task automatic do_idle();
    step(1'b0, 1'b1, '0, 1'b0, 1'b1, 1'b1, 1'b0, '1, 1'b0);
  endtask

  task automatic do_stall();
    step(1'b0, 1'b0, '1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int unsigned r;
    void'($urandom(32'h5EED_1234));
    model_clear();
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(rdata_oe_o === 1'b0, "drive in reset", W'(rdata_oe_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    do_idle();
    do_idle();

    // R3: fill every word with full-mask writes, then read all back
    tag = "R3";
    for (int i = 0; i < (1 << AW); i++) do_load(1'b0, AW'(i), '0);
    do_idle(); do_idle();
    for (int i = 0; i < (1 << AW); i++) do_load(1'b1, AW'(i), '1);
    do_idle(); do_idle();
    // R3: alternate write/read on consecutive edges
    for (int i = 0; i < 8; i++) begin
      do_load(1'b0, AW'(i + 16), '0);
      do_load(1'b1, AW'(i + 8), '0);
    end
    do_idle(); do_idle();

    // R12: partial write then immediate read of the same word
    tag = "R12";
    do_load(1'b0, 6'd5, 4'b1010);
    do_load(1'b1, 6'd5, 4'b1111);
    do_load(1'b1, 6'd5, 4'b0000);
    do_idle(); do_idle();

    // R4: only the top byte enabled
    tag = "R4";
    do_load(1'b0, 6'd9, 4'b0111);
    do_idle();
    do_load(1'b1, 6'd9, 4'b1111);
    do_idle(); do_idle();

    // R5: byte enables low on reads must not disturb the word
    tag = "R5";
    do_load(1'b1, 6'd7, 4'b0000);
    do_load(1'b1, 6'd7, 4'b0000);
    do_load(1'b1, 6'd7, 4'b0000);
    do_idle(); do_idle();

    // R6: write burst from offset 2 with chip enable dropped on advances, read it back
    tag = "R6";
    do_load(1'b0, 6'h0E, 4'b0000);
    do_adv(4'b1100, 1'b1);
    do_adv(4'b0000, 1'b1);
    do_adv(4'b0101, 1'b0);
    do_idle(); do_idle();
    do_load(1'b1, 6'h0E, 4'b1111);
    do_adv(4'b0000, 1'b1);
    do_adv(4'b0000, 1'b0);
    do_adv(4'b0000, 1'b1);
    do_adv(4'b0000, 1'b1);
    do_idle(); do_idle();

    // R7: advances with no open burst issue nothing
    tag = "R7";
    do_adv(4'b0000, 1'b0);
    do_adv(4'b0000, 1'b0);
    do_adv(4'b0000, 1'b0);

    // R8: deselect straight after reads, and deselect through cs3
    tag = "R8";
    do_load(1'b1, 6'd3, 4'b1111);
    do_load(1'b1, 6'd4, 4'b1111);
    step(1'b0, 1'b1, 6'd4, 1'b0, 1'b0, 1'b1, 1'b1, '1, 1'b0);
    do_adv(4'b1111, 1'b0);
    do_idle(); do_idle();

    // R1: a low strobe with a false chip enable loads nothing
    tag = "R1";
    step(1'b0, 1'b1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, '1, 1'b0);
    step(1'b0, 1'b1, 6'd2, 1'b0, 1'b1, 1'b1, 1'b0, '1, 1'b0);
    do_idle(); do_idle();

    // R9: stalls during read and write data phases
    tag = "R9";
    do_load(1'b1, 6'd20, 4'b1111);
    do_load(1'b0, 6'd21, 4'b0000);
    do_stall(); do_stall();
    do_load(1'b1, 6'd21, 4'b1111);
    do_stall();
    do_load(1'b1, 6'd20, 4'b1111);
    do_stall(); do_stall(); do_stall();
    do_idle(); do_idle(); do_idle();

    // R10: output enable masked on read data phases
    tag = "R10";
    do_load(1'b1, 6'd1, 4'b1111);
    do_load(1'b1, 6'd2, 4'b1111);
    step(1'b0, 1'b1, 6'd3, 1'b0, 1'b0, 1'b1, 1'b0, '1, 1'b1);
    step(1'b0, 1'b1, 6'd3, 1'b0, 1'b1, 1'b1, 1'b0, '1, 1'b0);
    step(1'b0, 1'b1, 6'd3, 1'b0, 1'b1, 1'b1, 1'b0, '1, 1'b1);
    do_idle();

    // R2: mixed random traffic
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      r = $urandom();
      step(r[1:0] == 2'd0, r[2], AW'(r[13:8]), r[6:3] == 4'd0, r[19:16] == 4'd0,
           r[23:20] != 4'd0, 1'b0, NB'(r[27:24]), r[31:28] == 4'd0);
    end
    do_idle(); do_idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule